// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the host-facing register file of a four-channel DMA controller with an 8-bit data path. A host issues byte-wide reads and writes over a small port space. The block keeps, for each channel, a 16-bit base and current address, a 16-bit base and current count, an 8-bit page (address bits 23:16) and a six-bit transfer mode. It also holds a four-bit channel mask, a command byte and a status byte. All of these are exported to a separate transfer engine. The engine reports request and terminal-count events back through pulse inputs.

The 16-bit registers are reached through 8-bit ports. One shared low/high byte pointer selects which half an access touches. Most software first clears the pointer and then writes the low byte followed by the high byte. Command ports manipulate the masks and the pointer, and one port performs a master clear of the control state.

Top module: `dma_regfile`

## Requirements
- R1: After reset every mask bit is 1, the byte pointer, status, command and read-data output are 0, and every channel's address, count, page and mode fields are 0.
- R2: Ports 0x00, 0x02, 0x04 and 0x06 hold the address of channels 0 to 3. Ports 0x01, 0x03, 0x05 and 0x07 hold the count (channel = port >> 1). A write with the pointer at 0 loads base and current with {8'h00, data}. A write with the pointer at 1 ORs data into bits 15:8 of both.
- R3: Every read or write of ports 0x00 to 0x07 toggles the byte pointer. A write of any value to port 0x0C sets the pointer to 0.
- R4: A read returns its byte on host_rdata in the cycle after host_rd, and host_rdata holds its value otherwise. An address or count read returns the current value's low byte when the pointer is 0 and its high byte when it is 1. When host_wr and host_rd are both high, only the write takes effect.
- R5: A read of port 0x08 returns request flags of channels 3..0 in bits 7..4 and terminal-count flags of channels 3..0 in bits 3..0. It then clears the terminal-count flags and keeps the request flags. An engine terminal-count pulse in the same cycle survives the clear.
- R6: eng_req_set sets request flags, eng_req_clr clears them (set wins), and eng_tc_set sets terminal-count flags. A write to port 0x09 with data bit 2 at 0 clears the request flag of channel data[1:0]. With bit 2 at 1 the write has no effect.
- R7: A write to port 0x0A sets mask[data[1:0]] to data[2]. A write to 0x0E clears all masks. A write to 0x0F loads masks 3..0 from data bits 3..0.
- R8: A write to port 0x0B loads the mode of channel data[1:0]. mode_o for that channel is {kind=data[7:6], decrement=data[5], autoinit=data[4], transfer=data[3:2]}, six bits, kind in the top bits.
- R9: A write to port 0x0D sets all masks and clears command, status flags and the byte pointer. It takes priority over engine pulses in the same cycle and leaves address, count, page and mode untouched.
- R10: Page registers sit at port 0x87 (channel 0), 0x83 (channel 1), 0x81 (channel 2) and 0x82 (channel 3). A write loads the byte and a read returns it unchanged.
- R11: A write to port 0x08 loads the command byte shown on cmd_o.
- R12: A read of any other port, including 0x09 to 0x0F, returns 0xFF. A write to a port outside 0x00 to 0x0F and the four page ports changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Port number |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| eng_req_set | input | 4 | Engine: set request flag per channel |
| eng_req_clr | input | 4 | Engine: clear request flag per channel |
| eng_tc_set | input | 4 | Engine: set terminal-count flag per channel |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |
| base_addr_o | output | 64 | Base address, 16 bits per channel, channel 0 lowest |
| cur_addr_o | output | 64 | Current address per channel |
| base_cnt_o | output | 64 | Base count per channel |
| cur_cnt_o | output | 64 | Current count per channel |
| page_o | output | 32 | Page byte per channel |
| mode_o | output | 24 | Mode, 6 bits per channel |

## Verification
Each write and each read side effect (pointer toggle, terminal-count clear, engine pulse) registers once, so it is visible on the exported outputs one clock after the strobe. Read data also appears on host_rdata one clock after the strobe. The bench drives every access on a falling edge and keeps it for one cycle. It compares outputs on the next falling edge, after exactly one rising edge, against a bench-side model that is updated in the same order the requirements give: host action, then engine pulses, then master clear. Random traffic over mapped and unmapped ports is mixed with directed cases. These cover the high-byte OR, a read that moves the pointer between writes, a status read colliding with a terminal-count pulse, and a master clear colliding with engine pulses.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    localparam int CH_N   = 4;
    localparam int CH_W   = $clog2(CH_N);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int MODE_W = 6;

    typedef enum logic [3:0] {
        OP_NONE, OP_ADDR, OP_CNT, OP_STAT_CMD, OP_REQ, OP_MASK_ONE, OP_MODE,
        OP_FF_CLR, OP_MCLR, OP_MASK_CLR, OP_MASK_ALL, OP_PAGE
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [CH_W-1:0] ch;
    } port_sel_t;

    typedef struct packed {
        logic [1:0] kind;
        logic       addr_dec;
        logic       auto_init;
        logic [1:0] xfer;
    } chan_mode_t;

    typedef struct packed {
        logic [WORD_W-1:0] base_addr;
        logic [WORD_W-1:0] cur_addr;
        logic [WORD_W-1:0] base_cnt;
        logic [WORD_W-1:0] cur_cnt;
        logic [BYTE_W-1:0] page;
        chan_mode_t        mode;
    } chan_regs_t;

    typedef struct packed {
        logic              ff;
        logic [CH_N-1:0]   mask;
        logic [CH_N-1:0]   req;
        logic [CH_N-1:0]   tc;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] rdata;
    } ctl_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_i,
    output port_sel_t         sel_o
);
    always_comb begin
        sel_o.op = OP_NONE;
        sel_o.ch = '0;
        if (addr_i[BYTE_W-1:3] == '0) begin
            sel_o.op = addr_i[0] ? OP_CNT : OP_ADDR;
            sel_o.ch = addr_i[CH_W:1];
        end else begin
            case (addr_i)
                8'h08: sel_o.op = OP_STAT_CMD;
                8'h09: sel_o.op = OP_REQ;
                8'h0A: sel_o.op = OP_MASK_ONE;
                8'h0B: sel_o.op = OP_MODE;
                8'h0C: sel_o.op = OP_FF_CLR;
                8'h0D: sel_o.op = OP_MCLR;
                8'h0E: sel_o.op = OP_MASK_CLR;
                8'h0F: sel_o.op = OP_MASK_ALL;
                // R10: non-linear page port order
                8'h87: begin sel_o.op = OP_PAGE; sel_o.ch = 2'd0; end
                8'h83: begin sel_o.op = OP_PAGE; sel_o.ch = 2'd1; end
                8'h81: begin sel_o.op = OP_PAGE; sel_o.ch = 2'd2; end
                8'h82: begin sel_o.op = OP_PAGE; sel_o.ch = 2'd3; end
                default: sel_o.op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              hi_byte,
    input  logic              page_we,
    input  logic              mode_we,
    input  logic [BYTE_W-1:0] wdata_i,
    output chan_regs_t        regs_o
);
    chan_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (addr_we) begin
            if (!hi_byte) begin
                r_d.base_addr = {{BYTE_W{1'b0}}, wdata_i};
                r_d.cur_addr  = {{BYTE_W{1'b0}}, wdata_i};
            end else begin
                r_d.base_addr = r_q.base_addr | {wdata_i, {BYTE_W{1'b0}}};
                r_d.cur_addr  = r_q.cur_addr  | {wdata_i, {BYTE_W{1'b0}}};
            end
        end
        if (cnt_we) begin
            if (!hi_byte) begin
                r_d.base_cnt = {{BYTE_W{1'b0}}, wdata_i};
                r_d.cur_cnt  = {{BYTE_W{1'b0}}, wdata_i};
            end else begin
                r_d.base_cnt = r_q.base_cnt | {wdata_i, {BYTE_W{1'b0}}};
                r_d.cur_cnt  = r_q.cur_cnt  | {wdata_i, {BYTE_W{1'b0}}};
            end
        end
        if (page_we) r_d.page = wdata_i;
        if (mode_we) begin
            r_d.mode.kind      = wdata_i[7:6];
            r_d.mode.addr_dec  = wdata_i[5];
            r_d.mode.auto_init = wdata_i[4];
            r_d.mode.xfer      = wdata_i[3:2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs_o = r_q;

    // R2
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && !hi_byte) |=> (regs_o.cur_addr == {8'h00, $past(wdata_i)}
                                   && regs_o.base_addr == {8'h00, $past(wdata_i)}));
    // R2
    hi_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && hi_byte) |=> (regs_o.cur_cnt[15:8] ==
                                 ($past(regs_o.cur_cnt[15:8]) | $past(wdata_i))));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmareg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [BYTE_W-1:0]        host_addr,
    input  logic [BYTE_W-1:0]        host_wdata,
    output logic [BYTE_W-1:0]        host_rdata,
    input  logic [CH_N-1:0]          eng_req_set,
    input  logic [CH_N-1:0]          eng_req_clr,
    input  logic [CH_N-1:0]          eng_tc_set,
    output logic [CH_N-1:0]          mask_o,
    output logic [BYTE_W-1:0]        cmd_o,
    output logic [CH_N*WORD_W-1:0]   base_addr_o,
    output logic [CH_N*WORD_W-1:0]   cur_addr_o,
    output logic [CH_N*WORD_W-1:0]   base_cnt_o,
    output logic [CH_N*WORD_W-1:0]   cur_cnt_o,
    output logic [CH_N*BYTE_W-1:0]   page_o,
    output logic [CH_N*MODE_W-1:0]   mode_o
);
    port_sel_t  sel;
    chan_regs_t regs [CH_N];
    ctl_t       c_d, c_q;
    logic       rd_act;
    logic [CH_W-1:0] vch;
    logic [BYTE_W-1:0] rd_byte;

    dmareg_decode u_dec (.addr_i(host_addr), .sel_o(sel));

    assign rd_act = host_rd && !host_wr;
    assign vch    = host_wdata[CH_W-1:0];

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        dmareg_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr_we (host_wr && sel.op == OP_ADDR && sel.ch == g),
            .cnt_we  (host_wr && sel.op == OP_CNT  && sel.ch == g),
            .hi_byte (c_q.ff),
            .page_we (host_wr && sel.op == OP_PAGE && sel.ch == g),
            .mode_we (host_wr && sel.op == OP_MODE && vch == g),
            .wdata_i (host_wdata),
            .regs_o  (regs[g])
        );
        assign base_addr_o[g*WORD_W +: WORD_W] = regs[g].base_addr;
        assign cur_addr_o [g*WORD_W +: WORD_W] = regs[g].cur_addr;
        assign base_cnt_o [g*WORD_W +: WORD_W] = regs[g].base_cnt;
        assign cur_cnt_o  [g*WORD_W +: WORD_W] = regs[g].cur_cnt;
        assign page_o     [g*BYTE_W +: BYTE_W] = regs[g].page;
        assign mode_o     [g*MODE_W +: MODE_W] = regs[g].mode;
    end

    always_comb begin
        case (sel.op)
            OP_ADDR:     rd_byte = c_q.ff ? regs[sel.ch].cur_addr[15:8] : regs[sel.ch].cur_addr[7:0];
            OP_CNT:      rd_byte = c_q.ff ? regs[sel.ch].cur_cnt[15:8]  : regs[sel.ch].cur_cnt[7:0];
            OP_STAT_CMD: rd_byte = {c_q.req, c_q.tc};
            OP_PAGE:     rd_byte = regs[sel.ch].page;
            default:     rd_byte = '1;
        endcase
    end

    always_comb begin
        c_d = c_q;
        if (host_wr) begin
            case (sel.op)
                OP_ADDR, OP_CNT: c_d.ff = ~c_q.ff;
                OP_STAT_CMD:     c_d.cmd = host_wdata;
                OP_REQ:          if (!host_wdata[2]) c_d.req[vch] = 1'b0;
                OP_MASK_ONE:     c_d.mask[vch] = host_wdata[2];
                OP_FF_CLR:       c_d.ff = 1'b0;
                OP_MASK_CLR:     c_d.mask = '0;
                OP_MASK_ALL:     c_d.mask = host_wdata[CH_N-1:0];
                default: ;
            endcase
        end
        if (rd_act) begin
            c_d.rdata = rd_byte;
            if (sel.op == OP_ADDR || sel.op == OP_CNT) c_d.ff = ~c_q.ff;
            if (sel.op == OP_STAT_CMD) c_d.tc = '0;
        end
        c_d.req = (c_d.req & ~eng_req_clr) | eng_req_set;
        c_d.tc  = c_d.tc | eng_tc_set;
        if (host_wr && sel.op == OP_MCLR) begin
            c_d.mask = '1;
            c_d.cmd  = '0;
            c_d.req  = '0;
            c_d.tc   = '0;
            c_d.ff   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.mask  <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign host_rdata = c_q.rdata;
    assign mask_o     = c_q.mask;
    assign cmd_o      = c_q.cmd;

    // R3
    ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (sel.op == OP_ADDR || sel.op == OP_CNT)) |=> (c_q.ff != $past(c_q.ff)));
    // R5
    stat_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && sel.op == OP_STAT_CMD && eng_tc_set == '0)
            |=> (host_rdata == {$past(c_q.req), $past(c_q.tc)} && c_q.tc == '0));
    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h0E) |=> (mask_o == '0));
    // R9
    mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h0D) |=> (mask_o == '1 && cmd_o == '0 && !c_q.ff));
    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && sel.op == OP_NONE) |=> (host_rdata == 8'hFF));
endmodule

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic [7:0] host_rdata;
    logic [3:0] eng_req_set = '0, eng_req_clr = '0, eng_tc_set = '0;
    logic [3:0] mask_o;
    logic [7:0] cmd_o;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
    logic [31:0] page_o;
    logic [23:0] mode_o;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [15:0] mba[4], mca[4], mbc[4], mcc[4];
    logic [7:0]  mpg[4];
    logic [5:0]  mmd[4];
    logic [3:0]  mmask, mreq, mtc;
    logic [7:0]  mcmd;
    logic        mff;

    always #4 clk = ~clk;

    dma_regfile uut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int page_ch(logic [7:0] a);
        case (a)
            8'h87: return 0;
            8'h83: return 1;
            8'h81: return 2;
            8'h82: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        int c = int'(a[2:1]);
        if (a < 8'h08) begin
            if (a[0]) return mff ? mcc[c][15:8] : mcc[c][7:0];
            else      return mff ? mca[c][15:8] : mca[c][7:0];
        end
        if (a == 8'h08) return {mreq, mtc};
        if (page_ch(a) >= 0) return mpg[page_ch(a)];
        return 8'hFF;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            mba[i] = 0; mca[i] = 0; mbc[i] = 0; mcc[i] = 0; mpg[i] = 0; mmd[i] = 0;
        end
        mmask = 4'hF; mreq = 0; mtc = 0; mcmd = 0; mff = 0;
    endtask

    task automatic model_write(logic [7:0] a, logic [7:0] d);
        int c = int'(a[2:1]);
        int v = int'(d[1:0]);
        if (a < 8'h08) begin
            if (a[0]) begin
                mbc[c] = mff ? (mbc[c] | {d, 8'h00}) : {8'h00, d};
                mcc[c] = mff ? (mcc[c] | {d, 8'h00}) : {8'h00, d};
            end else begin
                mba[c] = mff ? (mba[c] | {d, 8'h00}) : {8'h00, d};
                mca[c] = mff ? (mca[c] | {d, 8'h00}) : {8'h00, d};
            end
            mff = ~mff;
        end else if (page_ch(a) >= 0) mpg[page_ch(a)] = d;
        else case (a)
            8'h08: mcmd = d;
            8'h09: if (!d[2]) mreq[v] = 1'b0;
            8'h0A: mmask[v] = d[2];
            8'h0B: mmd[v] = d[7:2];
            8'h0C: mff = 1'b0;
            8'h0D: begin mmask = 4'hF; mcmd = 0; mreq = 0; mtc = 0; mff = 0; end
            8'h0E: mmask = 4'h0;
            8'h0F: mmask = d[3:0];
            default: ;
        endcase
    endtask

    task automatic compare_all(string tag);
        chk({tag, " R7 mask"}, 32'(mask_o), 32'(mmask));
        chk({tag, " R11 cmd"}, 32'(cmd_o), 32'(mcmd));
        for (int i = 0; i < 4; i++) begin
            chk({tag, " R2 base_addr"}, 32'(base_addr_o[i*16 +: 16]), 32'(mba[i]));
            chk({tag, " R2 cur_addr"},  32'(cur_addr_o[i*16 +: 16]),  32'(mca[i]));
            chk({tag, " R2 base_cnt"},  32'(base_cnt_o[i*16 +: 16]),  32'(mbc[i]));
            chk({tag, " R2 cur_cnt"},   32'(cur_cnt_o[i*16 +: 16]),   32'(mcc[i]));
            chk({tag, " R10 page"},     32'(page_o[i*8 +: 8]),        32'(mpg[i]));
            chk({tag, " R8 mode"},      32'(mode_o[i*6 +: 6]),        32'(mmd[i]));
        end
    endtask

    // one host write with optional engine pulses in the same cycle
    task automatic wr(logic [7:0] a, logic [7:0] d, string tag,
                      logic [3:0] rs = 0, logic [3:0] rc = 0, logic [3:0] ts = 0);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        eng_req_set = rs; eng_req_clr = rc; eng_tc_set = ts;
        if (a != 8'h0D) model_write(a, d);
        mreq = (mreq & ~rc) | rs; mtc = mtc | ts;
        if (a == 8'h0D) model_write(a, d);
        @(negedge clk);
        host_wr = 0; eng_req_set = 0; eng_req_clr = 0; eng_tc_set = 0;
        compare_all(tag);
    endtask

    task automatic rd(logic [7:0] a, string tag, logic [3:0] ts = 0);
        logic [7:0] e;
        @(negedge clk);
        host_rd = 1; host_addr = a; eng_tc_set = ts;
        e = exp_read(a);
        if (a < 8'h08) mff = ~mff;
        if (a == 8'h08) mtc = 0;
        mtc = mtc | ts;
        @(negedge clk);
        host_rd = 0; eng_tc_set = 0;
        chk({tag, " R4 rdata"}, 32'(host_rdata), 32'(e));
    endtask

    task automatic eng(logic [3:0] rs, logic [3:0] rc, logic [3:0] ts);
        @(negedge clk);
        eng_req_set = rs; eng_req_clr = rc; eng_tc_set = ts;
        mreq = (mreq & ~rc) | rs; mtc = mtc | ts;
        @(negedge clk);
        eng_req_set = 0; eng_req_clr = 0; eng_tc_set = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ports[24];
        logic [7:0] tmp;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        compare_all("R1 reset");
        chk("R1 rdata", 32'(host_rdata), 32'h0);

        // R2/R3/R4: low then high byte on channel 1 address
        wr(8'h0C, 8'h00, "R3 ffclr");
        wr(8'h02, 8'h34, "R2 lo");
        wr(8'h02, 8'h12, "R2 hi");
        chk("R2 ch1 addr", 32'(cur_addr_o[31:16]), 32'h1234);
        rd(8'h02, "R4 lo byte");
        chk("R4 lo value", 32'(host_rdata), 32'h34);
        rd(8'h02, "R4 hi byte");
        chk("R4 hi value", 32'(host_rdata), 32'h12);
        // R2 high-byte OR: a read moves the pointer between two high writes
        wr(8'h05, 8'h0F, "R2 cnt lo");
        wr(8'h05, 8'h10, "R2 cnt hi");
        rd(8'h05, "R3 toggle by read");
        wr(8'h05, 8'h01, "R2 cnt or");
        chk("R2 or result", 32'(cur_cnt_o[47:32]), 32'h110F);
        // R3: port 0x0C resets pointer after a single low write
        wr(8'h06, 8'hAA, "R3 lo");
        wr(8'h0C, 8'h5A, "R3 clear");
        wr(8'h06, 8'hBB, "R3 lo again");
        chk("R3 lo again", 32'(cur_addr_o[63:48]), 32'h00BB);
        // R4: simultaneous read and write: write only
        @(negedge clk);
        host_wr = 1; host_rd = 1; host_addr = 8'h0F; host_wdata = 8'h05;
        tmp = host_rdata;
        model_write(8'h0F, 8'h05);
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        chk("R4 rdata held on write", 32'(host_rdata), 32'(tmp));
        compare_all("R4 rw");

        // R5/R6 status
        eng(4'b0101, 4'b0000, 4'b0011);
        rd(8'h08, "R5 status first");
        chk("R5 status value", 32'(host_rdata), 32'h53);
        rd(8'h08, "R5 status second");
        chk("R5 tc cleared", 32'(host_rdata), 32'h50);
        wr(8'h09, 8'h06, "R6 req ignore");
        wr(8'h09, 8'h02, "R6 req clr");
        rd(8'h08, "R6 status");
        chk("R6 req ch2 cleared", 32'(host_rdata), 32'h10);
        eng(4'b1000, 4'b0001, 4'b0000);
        rd(8'h08, "R6 engine set/clr");
        chk("R6 engine", 32'(host_rdata), 32'h80);
        rd(8'h08, "R5 collide", 4'b0100);
        rd(8'h08, "R5 tc survives");
        chk("R5 tc survives", 32'(host_rdata), 32'h84);

        // R7 masks
        wr(8'h0E, 8'hFF, "R7 clear all");
        wr(8'h0A, 8'h06, "R7 set one");
        wr(8'h0A, 8'h02, "R7 clr one");
        wr(8'h0F, 8'h0A, "R7 load all");
        // R8 mode
        wr(8'h0B, 8'b10_1_1_01_11, "R8 mode ch3");
        chk("R8 mode ch3", 32'(mode_o[23:18]), 32'b10_1_1_01);
        // R10 pages
        wr(8'h87, 8'hA0, "R10 p0");
        wr(8'h83, 8'hA1, "R10 p1");
        wr(8'h81, 8'hA2, "R10 p2");
        wr(8'h82, 8'hA3, "R10 p3");
        chk("R10 map", page_o, 32'hA3A2A1A0);
        rd(8'h81, "R10 read p2");
        chk("R10 read p2 value", 32'(host_rdata), 32'hA2);
        // R11 command
        wr(8'h08, 8'h04, "R11 cmd");
        // R12 unmapped
        wr(8'h84, 8'hFF, "R12 w84");
        wr(8'hC0, 8'hFF, "R12 wC0");
        wr(8'h10, 8'h0D, "R12 w10");
        rd(8'h0D, "R12 r0D");
        rd(8'h84, "R12 r84");
        // R9 master clear colliding with engine
        eng(4'b0011, 4'b0000, 4'b0011);
        wr(8'h0D, 8'h00, "R9 mclr", 4'b1100, 4'b0000, 4'b1100);
        rd(8'h08, "R9 status zero");
        chk("R9 status", 32'(host_rdata), 32'h00);

        // random traffic
        ports = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                  8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F,
                  8'h81, 8'h82, 8'h83, 8'h87, 8'h84, 8'h10, 8'hC4, 8'h55};
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a, d;
            int k = int'($urandom_range(0, 23));
            a = ports[k];
            if (a == 8'h0D && $urandom_range(0, 3) != 0) a = 8'h02;
            d = 8'($urandom);
            case ($urandom_range(0, 5))
                0, 1, 2: wr(a, d, "rand wr");
                3, 4:    rd(a, "rand rd", 4'($urandom_range(0, 1) != 0 ? $urandom : 0));
                default: eng(4'($urandom), 4'($urandom), 4'($urandom));
            endcase
        end
        compare_all("final");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule